// File: doc/BRIEF.md
# Serial Command Converter Sequencer

This block is the digital sequencer of a serial 14-bit successive-approximation converter. A host drives a three-wire port made of an active-low select, a serial clock and a data line. The host sends an 8-bit command that picks the output coding, the conversion clock source and an operating mode, and that loads a 3-bit general-purpose output port. The block then times acquisition and conversion, runs a calibration interval or performs a power-down conversion, drives a status strobe, and returns the result MSB first on a serial data output. A parallel 14-bit sample input stands in for the analog array. A down-counter stands in for the calibration engine.

All serial-side inputs are sampled by the system clock through two-flop synchronizers and converted to edge events. A command starts with its first 1 bit, not with the select edge. Dropping the select line, or finishing an operation, re-arms start detection. A fresh start bit abandons whatever operation is in progress.

Top module: `fe_seq`

## Requirements
- R1: After reset the port outputs are 0, internal-clock mode is selected (the strobe is driven and high while idle, even with select high), bipolar coding is selected, and start detection is armed.
- R2: While armed with select low, zero bits sampled on serial-clock rising edges are ignored. The first 1 is taken as command bit 7. Once a start bit is taken, further 1 bits are not start bits until select falls again or the operation ends.
- R3: Command bits in arrival order are: bit7 start, bit6 coding (1 = unipolar), bit5 clock source (1 = internal), bits 4:3 mode, bits 2:0 port value. Mode 00 = short acquisition, 01 = calibration, 10 = power-down conversion, 11 = long acquisition.
- R4: The data output enable is low while select is high. In external-clock mode the strobe enable is also low while select is high. In internal-clock mode the strobe is always driven.
- R5: External clock, short acquisition: counting falling serial-clock edges from the start bit, the strobe is high only between fall 7 and fall 8. The MSB appears at fall 8, one bit follows per fall down to the LSB at fall 21, and zeros follow after that.
- R6: External clock, long acquisition: the same sequence with the strobe between fall 15 and fall 16, the MSB at fall 16 and the LSB at fall 29.
- R7: The result is the sample unchanged in unipolar coding. In bipolar coding the sample MSB is inverted (two's complement of an offset-binary sample).
- R8: Internal clock: the strobe falls at fall 7 (short) or fall 15 (long) and rises CONV_TICKS system cycles later with the MSB on the data output. Each later fall shifts out the next bit.
- R9: The port outputs take bits 2:0 when the eighth command bit is sampled, and they change at no other time except reset.
- R10: Calibration drives the strobe low (internal clock) or high (external clock) for CAL_TICKS system cycles, then returns it to the idle level.
- R11: Raising and lowering select during an operation re-arms start detection, and a new start bit then aborts the conversion or calibration and starts a new acquisition.
- R12: While select is high, serial-clock edges are ignored. An external-clock conversion resumes its bit count when select falls again.
- R13: A power-down command performs one conversion with the acquisition length of the most recent short or long command, and it leaves that length unchanged.
- R14: Holding the shutdown input low aborts any operation, returns the strobe to its idle level and leaves the port outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shdnN | input | 1 | Active-low shutdown, system-clock domain |
| csN | input | 1 | Active-low serial select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| din | input | 1 | Serial command data, asynchronous |
| sampleIn | input | 14 | Offset-binary sample standing in for the converter array |
| dout | output | 1 | Serial result data |
| doutOe | output | 1 | Output enable for dout (0 = high impedance) |
| strobe | output | 1 | Status strobe |
| strobeOe | output | 1 | Output enable for strobe (0 = high impedance) |
| portOut | output | 3 | General-purpose output port |

## Verification
On every cycle the assertions check that the data output stays disabled once select has been high through the synchronizer, and that a disabled strobe never comes with an enabled data output. They also check that the port outputs change only in the cycle that follows a synchronized serial-clock rise, and that they hold still under shutdown. Only the bench scenarios can show the falling-edge counts for strobe and MSB position in the two acquisition lengths, the result coding, the internal conversion and calibration intervals, abort by a re-armed start bit, clock edges ignored across a select gap, and the acquisition length that a power-down command reuses.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV_EXT,
    ST_CONV_INT,
    ST_CAL
  } feState_t;

  // strobes from the sequencer to the result/port datapath
  typedef struct packed {
    logic       holdLoad;   // capture the sample into the hold register
    logic       outLoad;    // move the held result into the output shifter
    logic       outShift;   // shift the output by one bit
    logic       portLoad;   // update the general-purpose port
    logic [2:0] portVal;
    logic       unipolar;
  } dpCtl_t;

endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end

endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import fe_pkg::*;
#(
  parameter int DATA_W     = 14,
  parameter int SHORT_ACQ  = 7,
  parameter int LONG_ACQ   = 15,
  parameter int CONV_TICKS = 32,
  parameter int CAL_TICKS  = 80000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   shdnN,
  input  logic   csS,
  input  logic   sclkS,
  input  logic   dinS,
  output dpCtl_t ctl,
  output logic   strobe,
  output logic   strobeOe,
  output logic   doutOe
);

  localparam int FALL_W = $clog2(LONG_ACQ + DATA_W + 2);
  localparam int MAX_T  = (CAL_TICKS > CONV_TICKS) ? CAL_TICKS : CONV_TICKS;
  localparam int CNT_W  = $clog2(MAX_T + 1);

  feState_t          state;
  logic              armed, curUni, curInt, lastLong;
  logic [1:0]        curMode, pTmp;
  logic [2:0]        rxCnt;
  logic [FALL_W-1:0] fallCnt, fallNext, acqLen;
  logic [CNT_W-1:0]  cnt;
  logic              sclkPrev, csPrev;
  logic              rise, fall, csFall, startHit, longSel, isCal;

  always_comb begin
    rise     = sclkS & ~sclkPrev & ~csS & shdnN;
    fall     = ~sclkS & sclkPrev & ~csS & shdnN;
    csFall   = ~csS & csPrev;
    startHit = rise & dinS & armed;
    isCal    = (curMode == 2'b01);
    longSel  = (curMode == 2'b11) || (curMode == 2'b10 && lastLong);
    acqLen   = longSel ? FALL_W'(LONG_ACQ) : FALL_W'(SHORT_ACQ);
    fallNext = fallCnt + FALL_W'(1);

    ctl.unipolar = curUni;
    ctl.portVal  = {pTmp, dinS};
    ctl.portLoad = rise && !startHit && (rxCnt == 3'd7);
    ctl.holdLoad = (state == ST_ACQ) && fall && (fallNext == acqLen) && !isCal;
    ctl.outLoad  = shdnN && !startHit &&
                   (((state == ST_CONV_EXT) && fall && (fallNext == acqLen + FALL_W'(1))) ||
                    ((state == ST_CONV_INT) && (cnt == '0)));
    ctl.outShift = fall && !ctl.outLoad;

    if (curInt)
      strobe = !((state == ST_CONV_INT) || (state == ST_CAL));
    else
      strobe = ((state == ST_CONV_EXT) && (fallCnt == acqLen)) || (state == ST_CAL);
    strobeOe = curInt | ~csS;
    doutOe   = ~csS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      armed    <= 1'b1;
      curUni   <= 1'b0;
      curInt   <= 1'b1;
      curMode  <= 2'b00;
      lastLong <= 1'b0;
      pTmp     <= 2'b00;
      rxCnt    <= 3'd0;
      fallCnt  <= '0;
      cnt      <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
      if (csFall) armed <= 1'b1;

      if (!shdnN) begin
        state <= ST_IDLE;
        armed <= 1'b1;
        rxCnt <= 3'd0;
      end else if (startHit) begin
        state   <= ST_ACQ;
        armed   <= 1'b0;
        rxCnt   <= 3'd1;
        fallCnt <= '0;
      end else begin
        // command bits after the start bit
        if (rise && rxCnt != 3'd0) begin
          case (rxCnt)
            3'd1:    curUni     <= dinS;
            3'd2:    curInt     <= dinS;
            3'd3:    curMode[1] <= dinS;
            3'd4:    curMode[0] <= dinS;
            3'd5:    pTmp[1]    <= dinS;
            3'd6:    pTmp[0]    <= dinS;
            default: ;
          endcase
          rxCnt <= (rxCnt == 3'd7) ? 3'd0 : rxCnt + 3'd1;
          if (rxCnt == 3'd7) begin
            if (curMode[1] == curMode[0]) lastLong <= curMode[1];
            if (isCal && state == ST_ACQ) begin
              state <= ST_CAL;
              cnt   <= CNT_W'(CAL_TICKS - 1);
            end
          end
        end

        case (state)
          ST_ACQ: if (fall) begin
            fallCnt <= fallNext;
            if (ctl.holdLoad) begin
              state <= curInt ? ST_CONV_INT : ST_CONV_EXT;
              cnt   <= CNT_W'(CONV_TICKS - 1);
            end
          end
          ST_CONV_EXT: if (fall) begin
            fallCnt <= fallNext;
            if (fallNext == acqLen + FALL_W'(DATA_W)) begin
              state <= ST_IDLE;
              armed <= 1'b1;
            end
          end
          ST_CONV_INT, ST_CAL: begin
            if (cnt == '0) begin
              state <= ST_IDLE;
              armed <= 1'b1;
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/fe_dp.sv
module fe_dp
  import fe_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              dout,
  output logic [PORT_W-1:0] portOut
);

  logic [DATA_W-1:0] holdReg, outSh, coded;

  always_comb begin
    coded = sampleIn;
    if (!ctl.unipolar) coded[DATA_W-1] = ~sampleIn[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      outSh   <= '0;
      portOut <= '0;
    end else begin
      if (ctl.holdLoad) holdReg <= coded;
      if (ctl.outLoad)       outSh <= holdReg;
      else if (ctl.outShift) outSh <= {outSh[DATA_W-2:0], 1'b0};
      if (ctl.portLoad) portOut <= ctl.portVal;
    end
  end

  assign dout = outSh[DATA_W-1];

endmodule

// File: rtl/fe_seq.sv
module fe_seq
  import fe_pkg::*;
#(
  parameter int DATA_W     = 14,
  parameter int SHORT_ACQ  = 7,
  parameter int LONG_ACQ   = 15,
  parameter int CONV_TICKS = 32,
  parameter int CAL_TICKS  = 80000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shdnN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              dout,
  output logic              doutOe,
  output logic              strobe,
  output logic              strobeOe,
  output logic [2:0]        portOut
);

  logic [2:0] pinSync;
  dpCtl_t     ctl;

  fe_sync #(.W(3), .RST_VAL(3'b001)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn({din, sclk, csN}), .syncOut(pinSync)
  );

  fe_ctrl #(
    .DATA_W(DATA_W), .SHORT_ACQ(SHORT_ACQ), .LONG_ACQ(LONG_ACQ),
    .CONV_TICKS(CONV_TICKS), .CAL_TICKS(CAL_TICKS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .shdnN(shdnN),
    .csS(pinSync[0]), .sclkS(pinSync[1]), .dinS(pinSync[2]),
    .ctl(ctl), .strobe(strobe), .strobeOe(strobeOe), .doutOe(doutOe)
  );

  fe_dp #(.DATA_W(DATA_W), .PORT_W(3)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(sampleIn),
    .dout(dout), .portOut(portOut)
  );

endmodule

// File: rtl/fe_seq_chk.sv
module fe_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       shdnN,
  input logic       csN,
  input logic       sclk,
  input logic       doutOe,
  input logic       strobeOe,
  input logic [2:0] portOut
);

  // R4: select high through the synchronizer disables the data output
  p_dout_hiz_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |-> !doutOe);

  // R4: a tri-stated strobe implies a tri-stated data output
  p_strobe_oe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobeOe |-> !doutOe);

  // R14: shutdown leaves the port untouched
  p_port_hold_r14: assert property (@(posedge clk) disable iff (!rstN)
    !shdnN |=> $stable(portOut));

  // R9: the port only moves right after a synchronized serial-clock rise
  p_port_update_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portOut) |-> ($past(sclk, 3) && !$past(sclk, 4)));

endmodule

bind fe_seq fe_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .shdnN(shdnN), .csN(csN), .sclk(sclk),
  .doutOe(doutOe), .strobeOe(strobeOe), .portOut(portOut)
);

// File: tb/fe_seq_tb_top.sv
`timescale 1ns/1ps
module fe_seq_tb_top;

  localparam int CONV_T = 32;
  localparam int CAL_T  = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0, shdnN = 1'b1, csN = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [13:0] sampleIn = '0;
  logic dout, doutOe, strobe, strobeOe;
  logic [2:0] portOut;

  int tests = 0, fails = 0;
  bit done = 0;
  logic sd, ss, sOe;

  always #2 clk = ~clk;

  fe_seq #(.CONV_TICKS(CONV_T), .CAL_TICKS(CAL_T)) dut_i (
    .clk(clk), .rstN(rstN), .shdnN(shdnN), .csN(csN), .sclk(sclk), .din(din),
    .sampleIn(sampleIn), .dout(dout), .doutOe(doutOe), .strobe(strobe),
    .strobeOe(strobeOe), .portOut(portOut)
  );

  function automatic logic [13:0] expCode(input logic [13:0] s, input logic uni);
    return uni ? s : {~s[13], s[12:0]};
  endfunction

  function automatic logic [7:0] mkCmd(input logic uni, input logic intc,
                                       input logic [1:0] mode, input logic [2:0] p);
    return {1'b1, uni, intc, mode, p};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    din = b;
    repeat (6) @(negedge clk);
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    sclk = 1'b0;
    repeat (6) @(negedge clk);
    sd = dout; ss = strobe; sOe = strobeOe;
  endtask

  task automatic csLow();
    csN = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic csHigh();
    csN = 1'b1; repeat (6) @(negedge clk);
  endtask

  // external-clock frame; gapAt > 0 inserts a select-high gap with ignored edges
  task automatic extFrame(input logic uni, input logic [1:0] mode, input logic [2:0] p,
                          input logic [13:0] smp, input logic expLong,
                          input int lead, input int gapAt, input string tag);
    logic [7:0] cmd = mkCmd(uni, 1'b0, mode, p);
    int acq = expLong ? 15 : 7;
    int total = expLong ? 32 : 24;
    logic [13:0] got = '0;
    bit strobeOk = 1, zeroOk = 1;
    sampleIn = smp;
    csLow();
    for (int i = 0; i < lead; i++) pulse(1'b0);
    for (int k = 1; k <= total; k++) begin
      pulse(k <= 8 ? cmd[8-k] : 1'b0);
      if (k >= 3 && (ss !== (k == acq) || sOe !== 1'b1)) strobeOk = 0;
      if (k > acq && k <= acq + 14) got = {got[12:0], sd};
      if (k > acq + 14 && sd !== 1'b0) zeroOk = 0;
      if (k == gapAt) begin
        csHigh();
        check(doutOe === 1'b0 && strobeOe === 1'b0, "R4 hi-z in gap", {doutOe, strobeOe}, 0);
        for (int g = 0; g < 3; g++) pulse(1'b1);
        din = 1'b0;
        csLow();
      end
    end
    check(strobeOk, {tag, " strobe position"}, acq, acq);
    check(got === expCode(smp, uni), {tag, " R7 data"}, got, expCode(smp, uni));
    check(zeroOk, {tag, " zero fill"}, 0, 0);
    check(portOut === p, "R9 port", portOut, p);
    csHigh();
  endtask

  task automatic intFrame(input logic uni, input logic isLong, input logic [2:0] p,
                          input logic [13:0] smp);
    logic [7:0] cmd = mkCmd(uni, 1'b1, isLong ? 2'b11 : 2'b00, p);
    int acq = isLong ? 15 : 7;
    int n = 0;
    logic [13:0] got;
    sampleIn = smp;
    csLow();
    for (int k = 1; k <= acq + 1; k++) begin
      pulse(k <= 8 ? cmd[8-k] : 1'b0);
      if (k == acq) check(ss === 1'b0, "R8 strobe low at start", ss, 0);
    end
    check(ss === 1'b0, "R8 strobe still low", ss, 0);
    while (strobe !== 1'b1 && n < 400) begin @(negedge clk); n++; end
    check(n > 0 && n < CONV_T, "R8 conversion time", n, CONV_T);
    got = {13'd0, dout};
    for (int b = 0; b < 13; b++) begin pulse(1'b0); got = {got[12:0], sd}; end
    check(got === expCode(smp, uni), "R8 R7 internal data", got, expCode(smp, uni));
    pulse(1'b0);
    check(sd === 1'b0, "R8 zero after LSB", sd, 0);
    check(portOut === p, "R9 port", portOut, p);
    csHigh();
  endtask

  task automatic sendBits(input logic [7:0] cmd);
    for (int k = 1; k <= 8; k++) pulse(cmd[8-k]);
  endtask

  task automatic doReset();
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; din = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int n;
    logic [2:0] pSaved;
    void'($urandom(32'd4242));
    doReset();
    // R1 reset state
    check(portOut === 3'b000, "R1 port reset", portOut, 0);
    check(strobeOe === 1'b1 && strobe === 1'b1, "R1 internal idle strobe", {strobeOe, strobe}, 3);
    check(doutOe === 1'b0, "R1 R4 dout hi-z", doutOe, 0);

    // R5 with leading zeros (R2), R3 field decode
    extFrame(1'b1, 2'b00, 3'b101, 14'h2A5C, 1'b0, 5, 0, "R5 R2");
    extFrame(1'b0, 2'b00, 3'b010, 14'h0001, 1'b0, 0, 0, "R5 R3");
    // R6 long acquisition
    extFrame(1'b1, 2'b11, 3'b111, 14'h3FFF, 1'b1, 2, 0, "R6");
    extFrame(1'b0, 2'b11, 3'b001, 14'h1234, 1'b1, 0, 0, "R6 R7");
    // R13 power-down reuses long, then short
    extFrame(1'b1, 2'b10, 3'b011, 14'h0F0F, 1'b1, 0, 0, "R13 long");
    extFrame(1'b1, 2'b00, 3'b000, 14'h0AAA, 1'b0, 0, 0, "R13 prep");
    extFrame(1'b0, 2'b10, 3'b110, 14'h3001, 1'b0, 0, 0, "R13 short");
    // R12 select gap in mid conversion
    extFrame(1'b1, 2'b00, 3'b100, 14'h1B3D, 1'b0, 0, 12, "R12");
    // R8 internal clock
    intFrame(1'b1, 1'b0, 3'b011, 14'h2468);
    intFrame(1'b0, 1'b1, 3'b100, 14'h0000);
    csHigh();
    check(strobeOe === 1'b1 && doutOe === 1'b0, "R4 internal strobe driven", {strobeOe, doutOe}, 2);

    // R10 internal calibration
    csLow();
    sendBits(mkCmd(1'b0, 1'b1, 2'b01, 3'b010));
    check(ss === 1'b0, "R10 int cal strobe low", ss, 0);
    n = 0;
    while (strobe !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    check(n > CAL_T - 50 && n < CAL_T + 5, "R10 int cal length", n, CAL_T);
    csHigh();
    // R10 external calibration
    csLow();
    sendBits(mkCmd(1'b0, 1'b0, 2'b01, 3'b001));
    check(ss === 1'b1 && sOe === 1'b1, "R10 ext cal strobe high", ss, 1);
    n = 0;
    while (strobe !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
    check(n > CAL_T - 50 && n < CAL_T + 5, "R10 ext cal length", n, CAL_T);
    csHigh();

    // R2 R11: no re-arm without select pulse; then abort calibration
    csLow();
    sendBits(mkCmd(1'b0, 1'b1, 2'b01, 3'b111));
    sendBits(mkCmd(1'b1, 1'b0, 2'b00, 3'b000));
    check(strobe === 1'b0 && portOut === 3'b111, "R2 R11 start ignored unarmed", {strobe, portOut}, 7);
    csHigh();
    intFrame(1'b1, 1'b0, 3'b001, 14'h3C3C);
    // R11 abort an external conversion mid-frame
    sampleIn = 14'h0BAD;
    csLow();
    sendBits(mkCmd(1'b1, 1'b0, 2'b00, 3'b110));
    for (int i = 0; i < 4; i++) pulse(1'b0);
    csHigh();
    extFrame(1'b1, 2'b00, 3'b011, 14'h1EE1, 1'b0, 0, 0, "R11 abort");

    // R14 shutdown during internal calibration
    csLow();
    sendBits(mkCmd(1'b0, 1'b1, 2'b01, 3'b101));
    pSaved = portOut;
    shdnN = 1'b0;
    repeat (10) @(negedge clk);
    check(strobe === 1'b1, "R14 strobe idle on shutdown", strobe, 1);
    check(portOut === pSaved, "R14 port kept", portOut, pSaved);
    shdnN = 1'b1;
    csHigh();
    extFrame(1'b0, 2'b00, 3'b010, 14'h2222, 1'b0, 0, 0, "R14 resume");

    // random mix
    for (int it = 0; it < 16; it++) begin
      logic uni = 1'($urandom);
      logic lng = 1'($urandom);
      logic [2:0] p = 3'($urandom);
      logic [13:0] s = 14'($urandom);
      if ($urandom % 2) intFrame(uni, lng, p, s);
      else extFrame(uni, lng ? 2'b11 : 2'b00, p, s, lng, int'($urandom % 3), 0,
                    lng ? "R6 rand" : "R5 rand");
    end

    // R1 mid-run reset
    doReset();
    check(portOut === 3'b000 && strobe === 1'b1 && strobeOe === 1'b1, "R1 reset after run",
          {portOut, strobe, strobeOe}, 3);
    // R1 default bipolar coding is visible through a mode that keeps it: none; check reset arming
    extFrame(1'b0, 2'b00, 3'b001, 14'h2001, 1'b0, 1, 0, "R1 R2 armed");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule